// File: doc/BRIEF.md
# Multicycle Instruction Step Controller

This block is the control state machine of a multicycle processor core for a small 32-bit load/store instruction subset. Each instruction is split into short steps, and each step uses at most one major functional unit. The external datapath holds the partial results in its own registers: the instruction register, two operand latches, the ALU result latch and the memory data latch. Each cycle, the controller tells that datapath which memory access, register write, mux routing and ALU operation to perform.

The controller reads only the opcode field of the instruction register. After a fetch step and a decode step, which are shared by every instruction, it branches into a class-specific tail. The decode step always reads both source registers and forms the branch target ahead of time, because the class is not known yet. As a result, each class completes after its own number of cycles: three, four or five. An opcode the controller does not recognise finishes after decode and performs no writes. All control outputs are registered.

Top module: `mcs_sequencer`

## Requirements
- R1: A synchronous active-high reset forces the fetch step. While reset is held, and in the first cycle after it is released, the outputs show the fetch controls.
- R2: The fetch step drives the following controls: mem_rd=1, mem_addr_sel=0 (address from PC), ir_wr=1, alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_op=0 (add), pc_wr=1, pc_src=0 (live ALU result). Every field not listed here or in R3 to R9 is zero.
- R3: The step after every fetch is decode. In decode, alu_a_sel=0, alu_b_sel=3 (immediate shifted left by two) and alu_op=0, whatever the opcode. In decode, no memory, register, PC or instruction-register write is active.
- R4: Register-type opcode 000000 takes four cycles. Its third step drives alu_a_sel=1 (A), alu_b_sel=0 (B) and alu_op=2 (function field). Its fourth step drives rf_wr=1, rf_dst_rd=1 (destination rd) and rf_src_mem=0 (ALU latch).
- R5: Load opcode 100011 takes five cycles. Its third step drives alu_a_sel=1, alu_b_sel=2 (sign-extended immediate) and alu_op=0. Its fourth step drives mem_rd=1 and mem_addr_sel=1 (ALU latch). Its fifth step drives rf_wr=1, rf_dst_rd=0 (destination rt) and rf_src_mem=1.
- R6: Store opcode 101011 takes four cycles. Its third step has the same address controls as in R5. Its fourth step drives mem_wr=1 and mem_addr_sel=1.
- R7: Branch-on-equal opcode 000100 takes three cycles. Its third step drives alu_a_sel=1, alu_b_sel=0, alu_op=1 (subtract), pc_wr_cond=1 and pc_src=1 (ALU latch holding the target).
- R8: Jump opcode 000010 takes three cycles. Its third step drives pc_wr=1 and pc_src=2 (jump target).
- R9: Any other opcode goes back to fetch right after decode. It takes two cycles and performs no write of any kind.
- R10: mem_rd and mem_wr are never active in the same cycle.
- R11: A program of nine four-cycle, two three-cycle and one five-cycle instructions runs for exactly 47 cycles, counted from its first fetch to the fetch that follows its last instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU latch |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU zero flag is set |
| pc_src | output | 2 | PC source: 0 = ALU result, 1 = ALU latch, 2 = jump target |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Write destination: 1 = rd field, 0 = rt field |
| rf_src_mem | output | 1 | Write data: 1 = memory data latch, 0 = ALU latch |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = A latch |
| alu_b_sel | output | 2 | ALU B input: 0 = B latch, 1 = 4, 2 = immediate, 3 = immediate shifted left by two |
| alu_op | output | 2 | ALU mode: 0 = add, 1 = subtract, 2 = follow function field |

## Verification
Directed runs of each opcode class are compared step by step against the control vector expected for that step. These runs separate the five tails from one another, and they also show whether an unknown opcode leaks any write. Back-to-back branches, and a reset asserted in the middle of a load, test that the controller re-enters fetch from the last step of a class and from inside one. A long random mix of valid and invalid opcodes, drawn from a fixed seed, checks the transitions between every pair of classes. A fixed 12-instruction program then measures its total cycle count at the ports, which confirms the combined lengths of the four-cycle, three-cycle and five-cycle classes.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_LD_MEM,
    ST_LD_WB,
    ST_ST_MEM,
    ST_R_EXEC,
    ST_R_WB,
    ST_BRANCH,
    ST_JUMP
  } step_t;

  typedef enum logic [2:0] {
    CL_REG,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH,
    CL_JUMP,
    CL_UNDEF
  } iclass_t;

  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] BSEL_REG   = 2'd0;
  localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'd1;
  localparam logic [SEL_W-1:0] BSEL_IMM   = 2'd2;
  localparam logic [SEL_W-1:0] BSEL_IMMSH = 2'd3;

  localparam logic [SEL_W-1:0] AOP_ADD  = 2'd0;
  localparam logic [SEL_W-1:0] AOP_SUB  = 2'd1;
  localparam logic [SEL_W-1:0] AOP_FUNC = 2'd2;

  localparam logic [SEL_W-1:0] PSRC_ALU   = 2'd0;
  localparam logic [SEL_W-1:0] PSRC_LATCH = 2'd1;
  localparam logic [SEL_W-1:0] PSRC_JUMP  = 2'd2;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             mem_addr_sel;
    logic             ir_wr;
    logic             pc_wr;
    logic             pc_wr_cond;
    logic [SEL_W-1:0] pc_src;
    logic             rf_wr;
    logic             rf_dst_rd;
    logic             rf_src_mem;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
  } ctrl_t;

endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
  import mcs_pkg::*;
#(
  parameter int             OPC_W     = 6,
  parameter logic [OPC_W-1:0] OP_REG    = 6'h00,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'h2b,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OPC_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic [OPC_W-1:0] opcode,
  output iclass_t          iclass
);

  always_comb begin
    if (opcode == OP_REG)         iclass = CL_REG;
    else if (opcode == OP_LOAD)   iclass = CL_LOAD;
    else if (opcode == OP_STORE)  iclass = CL_STORE;
    else if (opcode == OP_BRANCH) iclass = CL_BRANCH;
    else if (opcode == OP_JUMP)   iclass = CL_JUMP;
    else                          iclass = CL_UNDEF;
  end

endmodule

// File: rtl/mcs_next.sv
module mcs_next
  import mcs_pkg::*;
(
  input  step_t   cur,
  input  iclass_t iclass,
  output step_t   nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (iclass)
          CL_REG:             nxt = ST_R_EXEC;
          CL_LOAD, CL_STORE:  nxt = ST_ADDR;
          CL_BRANCH:          nxt = ST_BRANCH;
          CL_JUMP:            nxt = ST_JUMP;
          default:            nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (iclass == CL_LOAD) ? ST_LD_MEM : ST_ST_MEM;
      ST_LD_MEM: nxt = ST_LD_WB;
      ST_R_EXEC: nxt = ST_R_WB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_ctrl_dec.sv
module mcs_ctrl_dec
  import mcs_pkg::*;
(
  input  step_t step,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (step)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_wr     = 1'b1;
        ctrl.pc_wr     = 1'b1;
        ctrl.alu_b_sel = BSEL_FOUR;
        ctrl.alu_op    = AOP_ADD;
        ctrl.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = BSEL_IMMSH;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_IMM;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_LD_MEM: begin
        ctrl.mem_rd       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      ST_LD_WB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.rf_src_mem = 1'b1;
      end
      ST_ST_MEM: begin
        ctrl.mem_wr       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_REG;
        ctrl.alu_op    = AOP_FUNC;
      end
      ST_R_WB: begin
        ctrl.rf_wr     = 1'b1;
        ctrl.rf_dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = BSEL_REG;
        ctrl.alu_op     = AOP_SUB;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = PSRC_LATCH;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = PSRC_JUMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int               OPC_W     = 6,
  parameter logic [OPC_W-1:0] OP_REG    = 6'h00,
  parameter logic [OPC_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OP_STORE  = 6'h2b,
  parameter logic [OPC_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OPC_W-1:0] OP_JUMP   = 6'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_addr_sel,
  output logic             ir_wr,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_src,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             rf_src_mem,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op
);

  iclass_t iclass;
  step_t   step_q;
  step_t   step_d;
  step_t   dec_in;
  ctrl_t   ctrl_d;
  ctrl_t   ctrl_q;

  mcs_classify #(
    .OPC_W(OPC_W), .OP_REG(OP_REG), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_classify (
    .opcode(opcode),
    .iclass(iclass)
  );

  mcs_next u_next (
    .cur   (step_q),
    .iclass(iclass),
    .nxt   (step_d)
  );

  // Decode the step about to be entered so the controls register alongside it.
  assign dec_in = rst ? ST_FETCH : step_d;

  mcs_ctrl_dec u_dec (
    .step(dec_in),
    .ctrl(ctrl_d)
  );

  always_ff @(posedge clk) begin
    step_q <= dec_in;
    ctrl_q <= ctrl_d;
  end

  assign mem_rd       = ctrl_q.mem_rd;
  assign mem_wr       = ctrl_q.mem_wr;
  assign mem_addr_sel = ctrl_q.mem_addr_sel;
  assign ir_wr        = ctrl_q.ir_wr;
  assign pc_wr        = ctrl_q.pc_wr;
  assign pc_wr_cond   = ctrl_q.pc_wr_cond;
  assign pc_src       = ctrl_q.pc_src;
  assign rf_wr        = ctrl_q.rf_wr;
  assign rf_dst_rd    = ctrl_q.rf_dst_rd;
  assign rf_src_mem   = ctrl_q.rf_src_mem;
  assign alu_a_sel    = ctrl_q.alu_a_sel;
  assign alu_b_sel    = ctrl_q.alu_b_sel;
  assign alu_op       = ctrl_q.alu_op;

endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk #(
  parameter int OPC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_addr_sel,
  input logic             ir_wr,
  input logic             pc_wr,
  input logic             pc_wr_cond,
  input logic [1:0]       pc_src,
  input logic             rf_wr,
  input logic             rf_dst_rd,
  input logic             rf_src_mem,
  input logic             alu_a_sel,
  input logic [1:0]       alu_b_sel,
  input logic [1:0]       alu_op
);

  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ir_wr);

  assert_decode_target_R3: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!alu_a_sel && alu_b_sel == 2'd3 && !rf_wr && !mem_wr &&
               !pc_wr && !pc_wr_cond && !ir_wr));

  assert_reg_wb_after_exec_R4: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_dst_rd) |-> $past(alu_op == 2'd2));

  assert_load_wb_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_src_mem) |-> $past(mem_rd && mem_addr_sel));

  assert_store_ends_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr);

  assert_branch_ends_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr);

  assert_jump_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == 2'd2) |=> ir_wr);

endmodule

bind mcs_sequencer mcs_sequencer_chk #(.OPC_W(OPC_W)) u_chk (.*);

// File: tb/mcs_sequencer_bench.sv
module mcs_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       mem_rd, mem_wr, mem_addr_sel, ir_wr, pc_wr, pc_wr_cond;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic       rf_wr, rf_dst_rd, rf_src_mem, alu_a_sel;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mcs_sequencer u_mcs_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_sel(mem_addr_sel),
    .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .rf_src_mem(rf_src_mem),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  localparam logic [5:0] OP_REG = 6'h00, OP_LOAD = 6'h23, OP_STORE = 6'h2b,
                         OP_BRANCH = 6'h04, OP_JUMP = 6'h02;

  // Bench layout: {mem_rd,mem_wr,addr_sel,ir_wr,pc_wr,pc_wr_cond,pc_src,
  //                rf_wr,rf_dst_rd,rf_src_mem,alu_a_sel,alu_b_sel,alu_op}
  function automatic logic [15:0] vec_now();
    return {mem_rd, mem_wr, mem_addr_sel, ir_wr, pc_wr, pc_wr_cond, pc_src,
            rf_wr, rf_dst_rd, rf_src_mem, alu_a_sel, alu_b_sel, alu_op};
  endfunction

  function automatic logic [15:0] mk(bit rd, bit wr, bit asel, bit irw, bit pcw,
                                     bit pcc, logic [1:0] psrc, bit rfw, bit dst,
                                     bit smem, bit a, logic [1:0] b, logic [1:0] op);
    return {rd, wr, asel, irw, pcw, pcc, psrc, rfw, dst, smem, a, b, op};
  endfunction

  function automatic bit is_known(logic [5:0] op);
    return op == OP_REG || op == OP_LOAD || op == OP_STORE ||
           op == OP_BRANCH || op == OP_JUMP;
  endfunction

  function automatic int op_len(logic [5:0] op);
    case (op)
      OP_REG, OP_STORE:    return 4;
      OP_LOAD:             return 5;
      OP_BRANCH, OP_JUMP:  return 3;
      default:             return 2;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(logic [5:0] op, int step);
    if (step == 0) return mk(1,0,0,1,1,0,2'd0,0,0,0,0,2'd1,2'd0);  // R2
    if (step == 1) return mk(0,0,0,0,0,0,2'd0,0,0,0,0,2'd3,2'd0);  // R3
    case (op)
      OP_REG:    return (step == 2) ? mk(0,0,0,0,0,0,2'd0,0,0,0,1,2'd0,2'd2)
                                    : mk(0,0,0,0,0,0,2'd0,1,1,0,0,2'd0,2'd0);
      OP_LOAD:   return (step == 2) ? mk(0,0,0,0,0,0,2'd0,0,0,0,1,2'd2,2'd0)
                      : (step == 3) ? mk(1,0,1,0,0,0,2'd0,0,0,0,0,2'd0,2'd0)
                                    : mk(0,0,0,0,0,0,2'd0,1,0,1,0,2'd0,2'd0);
      OP_STORE:  return (step == 2) ? mk(0,0,0,0,0,0,2'd0,0,0,0,1,2'd2,2'd0)
                                    : mk(0,1,1,0,0,0,2'd0,0,0,0,0,2'd0,2'd0);
      OP_BRANCH: return mk(0,0,0,0,0,1,2'd1,0,0,0,1,2'd0,2'd1);
      default:   return mk(0,0,0,0,1,0,2'd2,0,0,0,0,2'd0,2'd0);
    endcase
  endfunction

  function automatic string req_of(logic [5:0] op, int step);
    if (step == 0) return "R2";
    if (step == 1) return "R3";
    case (op)
      OP_REG:    return "R4";
      OP_LOAD:   return "R5";
      OP_STORE:  return "R6";
      OP_BRANCH: return "R7";
      OP_JUMP:   return "R8";
      default:   return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Entered at a falling edge with the controller in fetch.
  task automatic run_instr(logic [5:0] op);
    for (int s = 0; s < op_len(op); s++) begin
      check(req_of(op, s), vec_now(), exp_vec(op, s));
      if (vec_now()[15] && vec_now()[14]) check("R10", 16'h1, 16'h0);
      if (s == 0) opcode = op;
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] rand_op();
    logic [5:0] o;
    case ($urandom % 6)
      0: o = OP_REG;
      1: o = OP_LOAD;
      2: o = OP_STORE;
      3: o = OP_BRANCH;
      4: o = OP_JUMP;
      default: begin
        o = 6'($urandom);
        while (is_known(o)) o = 6'($urandom);
      end
    endcase
    return o;
  endfunction

  logic [5:0] prog [12];

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_init;
    int cycles;
    int fetches;
    seed_init = $urandom(32'h5EED1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", vec_now(), exp_vec(OP_REG, 0));   // reset state
    rst = 1'b0;
    check("R1", vec_now(), exp_vec(OP_REG, 0));   // first cycle after release

    // Directed: each class, an unknown opcode, back-to-back branches.
    run_instr(OP_REG);
    run_instr(OP_LOAD);
    run_instr(OP_STORE);
    run_instr(OP_BRANCH);
    run_instr(OP_BRANCH);
    run_instr(OP_JUMP);
    run_instr(6'h3f);                               // R9 unknown opcode
    run_instr(OP_REG);

    // Reset in the middle of a load (R1).
    check("R2", vec_now(), exp_vec(OP_LOAD, 0));
    opcode = OP_LOAD;
    @(negedge clk);
    @(negedge clk);
    check("R5", vec_now(), exp_vec(OP_LOAD, 2));
    rst = 1'b1;
    @(negedge clk);
    check("R1", vec_now(), exp_vec(OP_LOAD, 0));
    rst = 1'b0;
    run_instr(OP_JUMP);

    // Fixed 12-instruction program (R11): nine 4-cycle, two 3-cycle, one 5-cycle.
    prog = '{OP_REG, OP_STORE, OP_REG, OP_BRANCH, OP_REG, OP_STORE,
             OP_LOAD, OP_REG, OP_STORE, OP_JUMP, OP_REG, OP_STORE};
    cycles = 0;
    fetches = 0;
    for (int g = 0; g < 200; g++) begin
      if (ir_wr) begin
        fetches++;
        if (fetches == 13) break;
        opcode = prog[fetches-1];
      end
      cycles++;
      @(negedge clk);
    end
    check("R11", 16'(cycles), 16'd47);

    // Random mix of classes and unknown opcodes.
    for (int k = 0; k < 400; k++) run_instr(rand_op());

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule